// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-programmed watchdog that counts down on an external tick enable, where one tick stands for 0.6 s. A timeout of N seconds is therefore programmed as N*10/6 ticks. Expiry happens in two stages. The first time the counter runs out, the block sets a timeout flag and reloads itself. If software has still not cleared that flag when the counter runs out again, the block sets a second-timeout flag and a boot flag. It also asks for a system reset, unless a no-reboot control bit holds that request back.

Software reaches the block through a plain register bus. The bus has a write strobe, a read strobe, a word address and four byte enables. Registers that belong together share one 32-bit word, so a single access reaches a pair of them. The second register of each pair sits in the upper halfword or byte. Read data is registered: it appears on the cycle after the read strobe.

Word map:
- Word 0: counter view [9:0] (writing it reloads the counter), data-in byte [23:16], data-out byte [31:24].
- Word 1: first status [15:0], second status [31:16].
- Word 2: first control [15:0], second control [31:16].
- Word 3: message bytes [7:0] and [15:8], watchdog-count byte [23:16], software-interrupt byte [31:24].
- Word 4: timer value [9:0].
- Words 5 to 7 read as zero.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset, the words read as follows: word 0 = 0x00000000, word 1 = 0x00000000, word 2 = 0x00080000 (second control = 0x0008), word 3 = 0x03000000 (software-interrupt byte = 0x03), word 4 = 0x00000004.
- R2: A write to word 0 with byte enable 0 or 1 set loads the counter from the timer value. Word 0 bits [9:0] show the counter and bits [15:10] read zero. A write that enables only bytes 2 and 3 updates the data bytes and does not reload the counter.
- R3: After a reload with timer value T, every unhalted tick decrements the counter. After T-1 ticks the counter reads 1 and the timeout flag (word 1 bit 3) is clear. The T-th tick sets the flag and reloads the counter to T.
- R4: The timer value is masked to 10 bits, so writing 0xFFFF to word 4 reads back 0x03FF.
- R5: Status bits are write-one-to-clear within enabled byte lanes. Writing 0 leaves them unchanged, and writing back a value just read clears every set bit.
- R6: An expiry while the timeout flag is set sets the second-timeout flag (word 1 bit 17) and the boot flag (word 1 bit 18). An expiry after the timeout flag was cleared sets only the timeout flag.
- R7: A second-stage expiry drives the reset-request output high for exactly one cycle, in the cycle after the expiring tick. It does so only when the no-reboot bit (word 2 bit 16) is 0. With that bit set, no pulse is issued, but the status flags still set.
- R8: While the halt bit (word 2 bit 11) is 1, ticks do not change the counter or the status. Clearing the bit resumes counting from the held value.
- R9: The control, message and data bytes read back exactly what was written, and only the byte lanes with their enable set are updated.
- R10: When a status clear and an expiry fall in the same cycle, the set wins. The second-stage decision uses the flag value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle tick enable, one watchdog tick |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Word address |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| wd_rst_req_o | output | 1 | One-cycle reset request on a second-stage expiry |

## Verification
The hardest state to reach from the ports is an expiry that lands in the same cycle as a software write that clears the timeout flag. A second hard case is a second-stage expiry while the no-reboot bit is set. The bench reaches the first case with a dedicated task that raises the tick and a status write on the same clock edge, after counting the counter down to 1. It reaches the second case by chaining two full countdowns without clearing status. A seeded random phase then mixes ticks, reloads, halts, timer changes and partial status clears. It compares every read against a bench model and counts reset pulses against the model's prediction.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT = 3'd0;
    localparam logic [ADDR_W-1:0] A_STS = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTL = 3'd2;
    localparam logic [ADDR_W-1:0] A_MSG = 3'd3;
    localparam logic [ADDR_W-1:0] A_TMR = 3'd4;

    // bit positions inside the 32-bit word
    localparam int unsigned TO_POS     = 3;
    localparam int unsigned SEC_POS    = 17;
    localparam int unsigned BOOT_POS   = 18;
    localparam int unsigned HALT_BIT   = 11;  // within first control
    localparam int unsigned NOREBT_BIT = 0;   // within second control

    localparam logic [15:0] CTL2_RST  = 16'h0008;
    localparam logic [7:0]  SWIRQ_RST = 8'h03;
    localparam int unsigned TMR_RST   = 4;

    function automatic logic [BUS_W-1:0] lane_merge(
        input logic [BUS_W-1:0]   old_v,
        input logic [BUS_W-1:0]   new_v,
        input logic [BUS_W/8-1:0] be
    );
        logic [BUS_W-1:0] r;
        for (int i = 0; i < BUS_W/8; i++) begin
            r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             halt_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] tmr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        expire_o = 1'b0;
        if (load_i) begin
            s_d.cnt = tmr_i;
        end else if (tick_i && !halt_i) begin
            if (s_q.cnt <= CNT_W'(1)) begin
                expire_o = 1'b1;
                s_d.cnt  = tmr_i;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic expire_i,
    input  logic no_reboot_i,
    input  logic clr_to_i,
    input  logic clr_sec_i,
    input  logic clr_boot_i,
    output logic to_o,
    output logic sec_o,
    output logic boot_o,
    output logic rst_req_o
);
    typedef struct packed {
        logic to;
        logic sec;
        logic boot;
        logic rst;
    } sts_state_t;

    sts_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rst = 1'b0;
        if (clr_to_i)   s_d.to   = 1'b0;
        if (clr_sec_i)  s_d.sec  = 1'b0;
        if (clr_boot_i) s_d.boot = 1'b0;
        // a set in the same cycle overrides the clear
        if (expire_i) begin
            if (s_q.to) begin
                s_d.sec  = 1'b1;
                s_d.boot = 1'b1;
                s_d.rst  = !no_reboot_i;
            end
            s_d.to = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign to_o      = s_q.to;
    assign sec_o     = s_q.sec;
    assign boot_o    = s_q.boot;
    assign rst_req_o = s_q.rst;
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic               rd_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BUS_W/8-1:0] be_i,
    input  logic [BUS_W-1:0]   wdata_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic               to_i,
    input  logic               sec_i,
    input  logic               boot_i,
    output logic [BUS_W-1:0]   rdata_o,
    output logic [CNT_W-1:0]   tmr_o,
    output logic               halt_o,
    output logic               no_reboot_o,
    output logic               load_o,
    output logic               clr_to_o,
    output logic               clr_sec_o,
    output logic               clr_boot_o
);
    typedef struct packed {
        logic [7:0]       dat_in;
        logic [7:0]       dat_out;
        logic [15:0]      ctl1;
        logic [15:0]      ctl2;
        logic [7:0]       msg1;
        logic [7:0]       msg2;
        logic [7:0]       wdcnt;
        logic [7:0]       swirq;
        logic [CNT_W-1:0] tmr;
        logic [BUS_W-1:0] rdata;
    } reg_state_t;

    reg_state_t       s_d, s_q;
    logic [BUS_W-1:0] img;
    logic [BUS_W-1:0] wmrg;
    logic [BUS_W-1:0] sts_img;
    logic             sts_wr;

    always_comb begin
        sts_img           = '0;
        sts_img[TO_POS]   = to_i;
        sts_img[SEC_POS]  = sec_i;
        sts_img[BOOT_POS] = boot_i;

        case (addr_i)
            A_CNT:   img = {s_q.dat_out, s_q.dat_in, 16'(cnt_i)};
            A_STS:   img = sts_img;
            A_CTL:   img = {s_q.ctl2, s_q.ctl1};
            A_MSG:   img = {s_q.swirq, s_q.wdcnt, s_q.msg2, s_q.msg1};
            A_TMR:   img = BUS_W'(s_q.tmr);
            default: img = '0;
        endcase

        wmrg = lane_merge(img, wdata_i, be_i);

        s_d = s_q;
        if (wr_i) begin
            case (addr_i)
                A_CNT: begin
                    s_d.dat_in  = wmrg[23:16];
                    s_d.dat_out = wmrg[31:24];
                end
                A_CTL: begin
                    s_d.ctl1 = wmrg[15:0];
                    s_d.ctl2 = wmrg[31:16];
                end
                A_MSG: begin
                    s_d.msg1  = wmrg[7:0];
                    s_d.msg2  = wmrg[15:8];
                    s_d.wdcnt = wmrg[23:16];
                    s_d.swirq = wmrg[31:24];
                end
                A_TMR:   s_d.tmr = wmrg[CNT_W-1:0];
                default: ;
            endcase
        end
        if (rd_i) s_d.rdata = img;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.ctl2  <= CTL2_RST;
            s_q.swirq <= SWIRQ_RST;
            s_q.tmr   <= CNT_W'(TMR_RST);
        end else begin
            s_q <= s_d;
        end
    end

    assign sts_wr      = wr_i && (addr_i == A_STS);
    assign load_o      = wr_i && (addr_i == A_CNT) && (be_i[0] || be_i[1]);
    assign clr_to_o    = sts_wr && be_i[TO_POS/8]   && wdata_i[TO_POS];
    assign clr_sec_o   = sts_wr && be_i[SEC_POS/8]  && wdata_i[SEC_POS];
    assign clr_boot_o  = sts_wr && be_i[BOOT_POS/8] && wdata_i[BOOT_POS];
    assign rdata_o     = s_q.rdata;
    assign tmr_o       = s_q.tmr;
    assign halt_o      = s_q.ctl1[HALT_BIT];
    assign no_reboot_o = s_q.ctl2[NOREBT_BIT];
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tick_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_W/8-1:0] bus_be_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    output logic [BUS_W-1:0]   bus_rdata_o,
    output logic               wd_rst_req_o
);
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] tmr_w;
    logic             expire_w;
    logic             halt_w;
    logic             no_reboot_w;
    logic             load_w;
    logic             clr_to_w;
    logic             clr_sec_w;
    logic             clr_boot_w;
    logic             to_w;
    logic             sec_w;
    logic             boot_w;

    wdt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (bus_wr_i),
        .rd_i        (bus_rd_i),
        .addr_i      (bus_addr_i),
        .be_i        (bus_be_i),
        .wdata_i     (bus_wdata_i),
        .cnt_i       (cnt_w),
        .to_i        (to_w),
        .sec_i       (sec_w),
        .boot_i      (boot_w),
        .rdata_o     (bus_rdata_o),
        .tmr_o       (tmr_w),
        .halt_o      (halt_w),
        .no_reboot_o (no_reboot_w),
        .load_o      (load_w),
        .clr_to_o    (clr_to_w),
        .clr_sec_o   (clr_sec_w),
        .clr_boot_o  (clr_boot_w)
    );

    wdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .halt_i   (halt_w),
        .load_i   (load_w),
        .tmr_i    (tmr_w),
        .cnt_o    (cnt_w),
        .expire_o (expire_w)
    );

    wdt_status sts_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .expire_i    (expire_w),
        .no_reboot_i (no_reboot_w),
        .clr_to_i    (clr_to_w),
        .clr_sec_i   (clr_sec_w),
        .clr_boot_i  (clr_boot_w),
        .to_o        (to_w),
        .sec_o       (sec_w),
        .boot_o      (boot_w),
        .rst_req_o   (wd_rst_req_o)
    );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic             halt_i,
    input logic             load_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] tmr_i,
    input logic             to_i,
    input logic             sec_i,
    input logic             boot_i,
    input logic             no_reboot_i,
    input logic             rst_req_i
);
    // R7
    rst_needs_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |-> (sec_i && boot_i));

    // R7
    rst_inhibit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_i |-> !$past(no_reboot_i));

    // R6
    second_after_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sec_i) |-> $past(to_i));

    // R8
    halt_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_i && !load_i) |=> (cnt_i == $past(cnt_i)));

    // R3
    timeout_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(to_i) |-> ($past(tick_i) && !$past(halt_i)));

    // R2
    reload_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_i == $past(tmr_i)));
endmodule

bind two_stage_wdt wdt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .halt_i      (halt_w),
    .load_i      (load_w),
    .cnt_i       (cnt_w),
    .tmr_i       (tmr_w),
    .to_i        (to_w),
    .sec_i       (sec_w),
    .boot_i      (boot_w),
    .no_reboot_i (no_reboot_w),
    .rst_req_i   (wd_rst_req_o)
);

// File: tb/two_stage_wdt_tb_top.sv
`timescale 1ns/1ps
module two_stage_wdt_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [2:0]  addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    bit done = 0;

    // bench model
    int m_cnt, m_tmr, m_pulse;
    bit m_to, m_sec, m_boot, m_halt;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_req) pulses++;

    two_stage_wdt dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_i       (tick),
        .bus_wr_i     (wr),
        .bus_rd_i     (rd),
        .bus_addr_i   (addr),
        .bus_be_i     (be),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .wd_rst_req_o (rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic [2:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        wr = 1'b0; be = '0;
    endtask

    task automatic rd_word(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    function automatic bit model_tick();
        bit p = 0;
        if (!m_halt) begin
            if (m_cnt <= 1) begin
                if (m_to) begin
                    m_sec = 1; m_boot = 1; p = 1;
                end
                m_to = 1;
                m_cnt = m_tmr;
            end else begin
                m_cnt--;
            end
        end
        return p;
    endfunction

    function automatic logic [31:0] model_sts();
        return (32'(m_to) << 3) | (32'(m_sec) << 17) | (32'(m_boot) << 18);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int snap;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_word(3'd0, v); chk("R1 word0", v, 32'h0000_0000);
        rd_word(3'd1, v); chk("R1 word1", v, 32'h0000_0000);
        rd_word(3'd2, v); chk("R1 word2", v, 32'h0008_0000);
        rd_word(3'd3, v); chk("R1 word3", v, 32'h0300_0000);
        rd_word(3'd4, v); chk("R1 word4", v, 32'h0000_0004);

        // R4 timer mask
        wr_word(3'd4, 32'h0000_FFFF, 4'b0011);
        rd_word(3'd4, v); chk("R4 timer mask", v, 32'h0000_03FF);

        // R9 control lanes
        wr_word(3'd2, 32'h0000_A5A5, 4'b0011);
        wr_word(3'd2, 32'h1234_5678, 4'b0100);
        rd_word(3'd2, v); chk("R9 control lanes", v, 32'h0034_A5A5);
        wr_word(3'd2, 32'h0008_0000, 4'b1111);
        wr_word(3'd3, 32'h1122_3344, 4'b1111);
        wr_word(3'd3, 32'hFFFF_FFFF, 4'b0010);
        rd_word(3'd3, v); chk("R9 message lanes", v, 32'h1122_FF44);

        // R2 data bytes without reload
        wr_word(3'd0, 32'hBEEF_0000, 4'b1100);
        rd_word(3'd0, v); chk("R2 data bytes no reload", v, 32'hBEEF_0000);

        // R2 R3 countdown
        wr_word(3'd4, 32'd5, 4'b1111);
        wr_word(3'd0, 32'd0, 4'b0001);
        rd_word(3'd0, v); chk("R2 reload value", {16'h0, v[15:0]}, 32'd5);
        ticks(4);
        rd_word(3'd0, v); chk("R3 count at T-1", {16'h0, v[15:0]}, 32'd1);
        rd_word(3'd1, v); chk("R3 flag clear at T-1", v, 32'h0);
        do_tick();
        rd_word(3'd1, v); chk("R3 flag on T-th tick", v, 32'h0000_0008);
        rd_word(3'd0, v); chk("R3 reload after expiry", {16'h0, v[15:0]}, 32'd5);

        // R5 write-one-to-clear
        wr_word(3'd1, 32'h0, 4'b1111);
        rd_word(3'd1, v); chk("R5 zero write keeps", v, 32'h0000_0008);
        wr_word(3'd1, 32'h0000_0008, 4'b1100);
        rd_word(3'd1, v); chk("R5 disabled lane keeps", v, 32'h0000_0008);
        wr_word(3'd1, 32'h0000_0008, 4'b0011);
        rd_word(3'd1, v); chk("R5 clear", v, 32'h0);

        // R6 R7 second stage with reset pulse
        ticks(5);
        ticks(4);
        chk("R7 no pulse before second", 32'(rst_req), 32'd0);
        do_tick();
        chk("R7 pulse high", 32'(rst_req), 32'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", 32'(rst_req), 32'd0);
        rd_word(3'd1, v); chk("R6 second and boot set", v, 32'h0006_0008);
        wr_word(3'd1, v, 4'b1111);
        rd_word(3'd1, v); chk("R5 write back clears", v, 32'h0);

        // R6 cleared first flag: no second stage
        ticks(5);
        wr_word(3'd1, 32'h0000_0008, 4'b1111);
        ticks(5);
        rd_word(3'd1, v); chk("R6 only timeout after clear", v, 32'h0000_0008);
        wr_word(3'd1, 32'hFFFF_FFFF, 4'b1111);

        // R7 no-reboot inhibits pulse
        wr_word(3'd2, 32'h0009_0000, 4'b1100);
        snap = pulses;
        ticks(10);
        repeat (2) @(negedge clk);
        chk("R7 inhibited pulse count", 32'(pulses), 32'(snap));
        rd_word(3'd1, v); chk("R7 flags with no-reboot", v, 32'h0006_0008);
        wr_word(3'd2, 32'h0008_0000, 4'b1100);
        wr_word(3'd1, 32'hFFFF_FFFF, 4'b1111);

        // R8 halt
        wr_word(3'd2, 32'h0000_0800, 4'b0011);
        wr_word(3'd4, 32'd3, 4'b1111);
        wr_word(3'd0, 32'd0, 4'b0011);
        ticks(5);
        rd_word(3'd0, v); chk("R8 halted count", {16'h0, v[15:0]}, 32'd3);
        rd_word(3'd1, v); chk("R8 halted status", v, 32'h0);
        wr_word(3'd2, 32'h0, 4'b0011);
        do_tick();
        rd_word(3'd0, v); chk("R8 resumed count", {16'h0, v[15:0]}, 32'd2);

        // R10 set wins over clear in the same cycle
        wr_word(3'd4, 32'd2, 4'b1111);
        wr_word(3'd0, 32'd0, 4'b0011);
        ticks(3);
        @(negedge clk);
        tick = 1'b1; wr = 1'b1; addr = 3'd1; wdata = 32'h0000_0008; be = 4'b0011;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0; be = '0;
        chk("R10 pulse on simultaneous", 32'(rst_req), 32'd1);
        rd_word(3'd1, v); chk("R10 set wins", v, 32'h0006_0008);

        // random phase with model
        wr_word(3'd1, 32'hFFFF_FFFF, 4'b1111);
        wr_word(3'd4, 32'd7, 4'b1111);
        wr_word(3'd0, 32'd0, 4'b0011);
        m_cnt = 7; m_tmr = 7; m_to = 0; m_sec = 0; m_boot = 0; m_halt = 0; m_pulse = 0;
        repeat (2) @(negedge clk);
        snap = pulses;
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 19));
            if (op < 11) begin
                do_tick();
                if (model_tick()) m_pulse++;
            end else if (op == 11) begin
                wr_word(3'd0, 32'd0, 4'b0001);
                m_cnt = m_tmr;
            end else if (op == 12) begin
                v = $urandom & 32'h0006_0008;
                wr_word(3'd1, v, 4'b1111);
                if (v[3]) m_to = 0;
                if (v[17]) m_sec = 0;
                if (v[18]) m_boot = 0;
            end else if (op == 13) begin
                m_halt = ($urandom_range(0, 3) == 0);
                wr_word(3'd2, m_halt ? 32'h0000_0800 : 32'h0, 4'b0011);
            end else if (op == 14) begin
                m_tmr = int'($urandom_range(0, 15));
                wr_word(3'd4, 32'(m_tmr), 4'b0011);
            end else if (op < 17) begin
                rd_word(3'd0, v);
                chk("R3 random counter", {16'h0, v[15:0]}, 32'(m_cnt));
            end else begin
                rd_word(3'd1, v);
                chk("R6 random status", v, model_sts());
            end
        end
        repeat (2) @(negedge clk);
        chk("R7 random pulse count", 32'(pulses - snap), 32'(m_pulse));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule